// File: doc/BRIEF.md
# Recirculating Serial Shift Register Chain

This block is a clocked serial memory built from `UNITS` identical shift units of `STAGES` bits each. A select input decides where the next bit for the head of the chain comes from. It can take fresh serial data, or a recirculate input that is usually wired back from the chain's own output so that a stored pattern circulates. A shift-enable input qualifies every move. When it is low, nothing changes, however long the clock runs.

Each unit passes its enable on to the next unit one clock later. It also passes the bit it has just pushed out of its last stage through a one-bit hand-off register. As a result, the whole chain acts as a single delay line of `STAGES*UNITS` bits. The tail unit's final stage is brought out in true and inverted form. The tail unit's delayed enable is brought out as a strobe, so that a further chain can be driven from it.

Top module: `recirc_shift_chain`

## Requirements
- R1: A synchronous active-high reset clears every stored bit and every enable pipeline register. After reset, `serOut` reads 0, `serOutN` reads 1 and `strobeOut` reads 0.
- R2: On a clock edge where `shiftEn` is 1 and `modeSel` is 0, the head stage loads `dataIn`, and `recircIn` has no effect.
- R3: On a clock edge where `shiftEn` is 1 and `modeSel` is 1, the head stage loads `recircIn`, and `dataIn` has no effect.
- R4: While no enable reaches a unit, none of its stages changes. In particular, `serOut` holds its value for any number of cycles in which `shiftEn` stays 0.
- R5: A bit accepted by an enabled edge appears on `serOut` after exactly `STAGES*UNITS` enabled edges, counting its own. It becomes visible `UNITS-1` clock cycles after the edge of the last of those enables (128 enables and 1 cycle with the defaults).
- R6: `serOutN` is always the logical inverse of `serOut`.
- R7: `strobeOut` equals `shiftEn` delayed by `UNITS` clock cycles, one register per unit.
- R8: Set up the chain as follows: `recircIn` tied to `serOut`, `modeSel` held at 1, and enables spaced at least `UNITS` cycles apart. The stored pattern then repeats on `serOut` with a period of `STAGES*UNITS` enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| shiftEn | input | 1 | Qualifies a shift of the head unit |
| modeSel | input | 1 | 0 selects `dataIn`, 1 selects `recircIn` for the head stage |
| dataIn | input | 1 | Fresh serial data |
| recircIn | input | 1 | Recirculation serial data |
| serOut | output | 1 | Final stage of the tail unit |
| serOutN | output | 1 | Inverse of `serOut` |
| strobeOut | output | 1 | Enable delayed through every unit, for chaining |

## Verification
The head stage changes on the edge that carries the enable. `strobeOut` follows `shiftEn` by `UNITS` edges. `serOut` and `serOutN` reflect the bit that completed `STAGES*UNITS` enables, and they do so `UNITS-1` edges after that last enable. The bench keeps an ideal delay line that updates on the enabled edges. It ages both the delay line's tail bit and the enable through small history registers of those exact depths. It samples 5 ns after each rising edge, so every comparison uses a value that is already due. The directed impulse tests check that output one sample before and one sample after the bit is due.

// File: rtl/srr_pkg.sv
package srr_pkg;

  typedef struct packed {
    logic shift;
    logic takeRecirc;
  } unit_strobe_t;

endpackage

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
#(
  parameter int UNITS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shiftEn,
  input  logic                     modeSel,
  output unit_strobe_t [UNITS-1:0] strobes,
  output logic                     strobeOut
);

  logic [UNITS-1:0] enReg;
  logic [UNITS:0]   enTap;

  assign enTap = {enReg, shiftEn};

  always_ff @(posedge clk) begin
    if (rst) enReg <= '0;
    else     enReg <= enTap[UNITS-1:0];
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_strobe
    assign strobes[u].shift = enTap[u];
    if (u == 0) begin : g_head
      assign strobes[u].takeRecirc = modeSel;
    end else begin : g_follow
      assign strobes[u].takeRecirc = 1'b0;
    end
  end

  assign strobeOut = enTap[UNITS];

endmodule

// File: rtl/srr_datapath.sv
module srr_datapath
  import srr_pkg::*;
#(
  parameter int STAGES = 64,
  parameter int UNITS  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  unit_strobe_t [UNITS-1:0] strobes,
  input  logic                     dataIn,
  input  logic                     recircIn,
  output logic                     headBit,
  output logic                     tailBit
);

  logic [UNITS-1:0] chainIn;

  assign chainIn[0] = dataIn;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [STAGES-1:0] stg;
    logic              feed;

    assign feed = strobes[u].takeRecirc ? recircIn : chainIn[u];

    always_ff @(posedge clk) begin
      if (rst)                 stg <= '0;
      else if (strobes[u].shift) stg <= {stg[STAGES-2:0], feed};
    end

    if (u + 1 < UNITS) begin : g_hand
      logic handOff;
      always_ff @(posedge clk) begin
        if (rst)                   handOff <= 1'b0;
        else if (strobes[u].shift) handOff <= stg[STAGES-1];
      end
      assign chainIn[u+1] = handOff;
    end

    if (u == 0) begin : g_headTap
      assign headBit = stg[0];
    end
    if (u == UNITS - 1) begin : g_tailTap
      assign tailBit = stg[STAGES-1];
    end
  end

endmodule

// File: rtl/recirc_shift_chain.sv
module recirc_shift_chain
  import srr_pkg::*;
#(
  parameter int STAGES = 64,
  parameter int UNITS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic shiftEn,
  input  logic modeSel,
  input  logic dataIn,
  input  logic recircIn,
  output logic serOut,
  output logic serOutN,
  output logic strobeOut
);

  unit_strobe_t [UNITS-1:0] strobes;
  logic headBit;
  logic tailBit;

  srr_ctrl #(.UNITS(UNITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .shiftEn   (shiftEn),
    .modeSel   (modeSel),
    .strobes   (strobes),
    .strobeOut (strobeOut)
  );

  srr_datapath #(.STAGES(STAGES), .UNITS(UNITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .recircIn (recircIn),
    .headBit  (headBit),
    .tailBit  (tailBit)
  );

  assign serOut  = tailBit;
  assign serOutN = ~tailBit;

endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int UNITS = 2
) (
  input logic clk,
  input logic rst,
  input logic shiftEn,
  input logic modeSel,
  input logic dataIn,
  input logic recircIn,
  input logic serOut,
  input logic serOutN,
  input logic strobeOut,
  input logic headBit
);

  logic [UNITS-1:0] enSeen;
  logic [UNITS:0]   enAge;

  assign enAge = {enSeen, shiftEn};

  always_ff @(posedge clk) begin
    if (rst) enSeen <= '0;
    else     enSeen <= enAge[UNITS-1:0];
  end

  // R1: reset clears the outputs and the head stage
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!serOut && serOutN && !strobeOut && !headBit));

  // R2: data input selected when mode is low
  a_r2_data_entry: assert property (@(posedge clk) disable iff (rst)
    (shiftEn && !modeSel) |=> (headBit == $past(dataIn)));

  // R3: recirculate input selected when mode is high
  a_r3_recirc_entry: assert property (@(posedge clk) disable iff (rst)
    (shiftEn && modeSel) |=> (headBit == $past(recircIn)));

  // R4: the tail holds while its unit sees no enable
  a_r4_tail_hold: assert property (@(posedge clk) disable iff (rst)
    !enAge[UNITS-1] |=> $stable(serOut));

  // R7: cascade strobe is the enable aged by one cycle per unit
  a_r7_strobe_age: assert property (@(posedge clk) disable iff (rst)
    strobeOut == enAge[UNITS]);

endmodule

bind recirc_shift_chain srr_checker #(.UNITS(UNITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shiftEn   (shiftEn),
  .modeSel   (modeSel),
  .dataIn    (dataIn),
  .recircIn  (recircIn),
  .serOut    (serOut),
  .serOutN   (serOutN),
  .strobeOut (strobeOut),
  .headBit   (headBit)
);

// File: tb/sim_recirc_shift_chain.sv
module sim_recirc_shift_chain;

  localparam int STAGES = 64;
  localparam int UNITS  = 2;
  localparam int DEPTH  = STAGES * UNITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftEn = 1'b0;
  logic modeSel = 1'b0;
  logic dataIn = 1'b0;
  logic recircReg = 1'b0;
  logic tieLoop = 1'b0;
  logic recircIn;
  logic serOut, serOutN, strobeOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  logic [DEPTH-1:0] refLine = '0;
  logic [UNITS-1:0] tailHist = '0;
  logic [UNITS-1:0] enHist = '0;

  always #10 clk = ~clk;

  assign recircIn = tieLoop ? serOut : recircReg;

  recirc_shift_chain #(.STAGES(STAGES), .UNITS(UNITS)) u0 (
    .clk(clk), .rst(rst), .shiftEn(shiftEn), .modeSel(modeSel),
    .dataIn(dataIn), .recircIn(recircIn),
    .serOut(serOut), .serOutN(serOutN), .strobeOut(strobeOut)
  );

  function automatic logic expSer();
    return tailHist[UNITS-1];
  endfunction

  function automatic logic expStrobe();
    return enHist[UNITS-1];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic md, input logic d,
                      input logic r, input logic tie);
    logic feed;
    @(negedge clk);
    shiftEn = en; modeSel = md; dataIn = d; recircReg = r; tieLoop = tie;
    feed = md ? (tie ? expSer() : r) : d;
    @(posedge clk);
    if (rst) begin
      refLine = '0; tailHist = '0; enHist = '0;
    end else begin
      if (en) refLine = {refLine[DEPTH-2:0], feed};
      tailHist = {tailHist[UNITS-2:0], refLine[DEPTH-1]};
      enHist   = {enHist[UNITS-2:0], en};
    end
    #5;
    check("R5 serOut vs delay-line model", serOut, expSer());
    check("R6 serOutN inverse", serOutN, ~expSer());
    check("R7 strobeOut aged enable", strobeOut, expStrobe());
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 serOut after reset", serOut, 1'b0);
    check("R1 serOutN after reset", serOutN, 1'b1);
    check("R1 strobeOut after reset", strobeOut, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [DEPTH-1:0] seen;
    int seed;
    seed = $urandom(32'd4031);

    // R1 reset state
    doReset();

    // R2 + R5: impulse via data path, recirculate driven opposite
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 1; i < DEPTH - 1; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 R5 bit not yet due after 127 enables", serOut, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 R5 data bit due after 128 enables", serOut, 1'b1);

    // R4: long idle with toggling inputs, output must hold
    for (int i = 0; i < 400; i++) step(1'b0, i[0], i[1], i[2], 1'b0);
    check("R4 serOut held through idle", serOut, 1'b1);

    // R3 + R5: impulse via recirculate path, data driven opposite
    doReset();
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 1; i < DEPTH - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R3 R5 bit not yet due after 127 enables", serOut, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R3 R5 recirculated bit due after 128 enables", serOut, 1'b1);

    // R8: load a random pattern, then close the loop with spaced enables
    doReset();
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'($urandom), 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 2 * DEPTH; i++) begin
      step(1'b1, 1'b1, 1'($urandom), 1'b0, 1'b1);
      step(1'b0, 1'b1, 1'($urandom), 1'b0, 1'b1);
      if (i < DEPTH) seen[i] = serOut;
      else check("R8 loop repeats with period 128 enables", serOut, seen[i-DEPTH]);
    end

    // Mixed random traffic over all modes and enable densities
    doReset();
    for (int seg = 0; seg < 30; seg++) begin
      int density;
      logic md, tie;
      density = int'($urandom_range(0, 3));
      md  = 1'($urandom);
      tie = md & 1'($urandom);
      for (int i = 0; i < 100; i++) begin
        logic en;
        en = (density == 3) ? 1'b1 : (int'($urandom_range(0, 3)) < density);
        step(en, md, 1'($urandom), 1'($urandom), tie);
      end
    end

    // R1: reset in the middle of activity
    doReset();

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule